// File: doc/BRIEF.md
# Serial Channel Loop Router

This block sits between one asynchronous serial channel's pins, its transmit and receive shift engines, and the CPU-facing character paths. A two-bit loop setting chooses one of four configurations. Normal runs receiver and transmitter independently. Echo sends the incoming line back out while characters still reach the CPU. Local loop turns the transmitter back into the receiver and holds the outgoing line idle. Remote loop echoes the line and cuts off the CPU on both sides. The shift engines, baud generation and character buffering live elsewhere. This block only steers bits and gates characters.

The loop setting is sampled on a one-per-bit enable, `bit_tick`, so a new setting takes hold at the next bit boundary and never part-way through a bit. Echoed line data passes through one register that loads on the same enable, so the outgoing line trails the incoming line by one bit period.

Both character paths use valid/ready handshakes. When a path is open, `valid` and the data go from source to sink, and the sink's `ready` comes back unchanged, so back-pressure reaches the source directly. When a path is closed, the sink sees `valid` low. The source sees `ready` high, so any offered character is accepted and dropped instead of stalling the producer.

Top module: `chan_loop_router`

## Requirements
- R1: After reset the active loop setting is normal (code 00), the echo register holds 1 (mark), both path-enable outputs are 1, and `txd_pin` equals `tx_ser_in`, which idles at 1.
- R2: The active loop setting changes only at a clock edge where `bit_tick` is 1, and it then takes the value of `mode_cfg`. Changes to `mode_cfg` at other edges have no effect on any output.
- R3: In normal mode (code 00), `txd_pin` equals `tx_ser_in` and `rx_ser_out` equals `rxd_pin`.
- R4: In echo mode (code 01), `txd_pin` shows the `rxd_pin` value sampled at the most recent `bit_tick` edge, and `rx_ser_out` equals `rxd_pin`. The CPU-to-transmitter path is closed and the receiver-to-CPU path is open.
- R5: In local loop mode (code 10), `txd_pin` is held at 1 and `rx_ser_out` equals `tx_ser_in`, so `rxd_pin` has no effect. Both character paths are open.
- R6: In remote loop mode (code 11), `txd_pin` shows the registered echo of `rxd_pin` and `rx_ser_out` equals `rxd_pin`. Both character paths are closed.
- R7: On an open path, `valid` and the data pass from source to sink and `ready` passes from sink to source unchanged. On a closed path, the sink's `valid` is 0 and the source's `ready` is 1.
- R8: `tx_path_en` is 1 exactly in codes 00 and 10. `rx_path_en` is 1 in every code except 11.
- R9: The echo register loads `rxd_pin` only at `bit_tick` edges. Changes to `rxd_pin` between ticks do not reach `txd_pin` in the echoing modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per 1x bit period |
| mode_cfg | input | 2 | Requested loop setting: 00 normal, 01 echo, 10 local, 11 remote |
| rxd_pin | input | 1 | External serial receive line |
| txd_pin | output | 1 | External serial transmit line |
| tx_ser_in | input | 1 | Serial output of the transmitter |
| rx_ser_out | output | 1 | Serial input to the receiver |
| cpu_tx_valid | input | 1 | CPU offers a character for transmission |
| cpu_tx_ready | output | 1 | Character accepted (or dropped when closed) |
| cpu_tx_data | input | CHAR_W | Character from CPU |
| xmt_valid | output | 1 | Character offered to transmitter |
| xmt_ready | input | 1 | Transmitter can take a character |
| xmt_data | output | CHAR_W | Character to transmitter |
| rcv_valid | input | 1 | Receiver has a character |
| rcv_ready | output | 1 | Character taken from receiver (or dropped) |
| rcv_data | input | CHAR_W | Character from receiver |
| cpu_rx_valid | output | 1 | Character offered to CPU |
| cpu_rx_ready | input | 1 | CPU can take a character |
| cpu_rx_data | output | CHAR_W | Character to CPU |
| tx_path_en | output | 1 | CPU-to-transmitter path open |
| rx_path_en | output | 1 | Receiver-to-CPU path open |

## Verification
The assertions check on every cycle that the active setting stays put between ticks, that a closed path drops its input and shows no output, that local loop holds the line at mark and feeds the transmitter back, and that in the echoing modes the outgoing line matches the line value from the previous tick. Two things can only be shown by the bench's scenarios: that the encoding maps each code to the right configuration, and that `rxd_pin` really has no effect in local loop while it is toggled. The same holds for a mode request or line change made between ticks staying invisible until the next tick. The bench also shows that data and back-pressure pass through open paths unchanged under random traffic.

// File: rtl/loop_router_pkg.sv
package loop_router_pkg;

  typedef enum logic [1:0] {
    LM_NORMAL = 2'b00,
    LM_ECHO   = 2'b01,
    LM_LOCAL  = 2'b10,
    LM_REMOTE = 2'b11
  } loop_mode_e;

  localparam int unsigned LOOP_MODE_W = 2;

  function automatic logic tx_path_open(loop_mode_e m);
    return (m == LM_NORMAL) || (m == LM_LOCAL);
  endfunction

  function automatic logic rx_path_open(loop_mode_e m);
    return (m != LM_REMOTE);
  endfunction

  function automatic logic line_echoes(loop_mode_e m);
    return (m == LM_ECHO) || (m == LM_REMOTE);
  endfunction

endpackage

// File: rtl/loop_mode_reg.sv
module loop_mode_reg
  import loop_router_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bit_tick,
  input  logic [LOOP_MODE_W-1:0] mode_cfg,
  output loop_mode_e             act_mode
);

  loop_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= LM_NORMAL;
    end else if (bit_tick) begin
      mode_q <= loop_mode_e'(mode_cfg);
    end
  end

  assign act_mode = mode_q;

  // R2: the setting may only move at a bit boundary
  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(bit_tick)) |-> $stable(mode_q));

  // R2: at a tick the requested code is adopted
  assert_mode_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(bit_tick)) |-> (mode_q == loop_mode_e'($past(mode_cfg))));

endmodule

// File: rtl/loop_serial_mux.sv
module loop_serial_mux
  import loop_router_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  loop_mode_e act_mode,
  input  logic       rxd,
  input  logic       tx_ser,
  output logic       txd,
  output logic       rx_ser
);

  logic echo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      echo_q <= 1'b1;
    end else if (bit_tick) begin
      echo_q <= rxd;
    end
  end

  always_comb begin
    unique case (act_mode)
      LM_NORMAL: txd = tx_ser;
      LM_LOCAL:  txd = 1'b1;
      default:   txd = echo_q;
    endcase
  end

  assign rx_ser = (act_mode == LM_LOCAL) ? tx_ser : rxd;

  // R4 / R6: echoed line trails the input by one tick
  assert_echo_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(bit_tick) && line_echoes(act_mode)) |-> (txd == $past(rxd)));

  // R9: between ticks the echoed line does not move
  assert_echo_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(bit_tick) && line_echoes(act_mode)
     && line_echoes($past(act_mode))) |-> $stable(txd));

  // R5: local loop idles the pin and feeds transmitter back
  assert_local_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == LM_LOCAL) |-> (txd && (rx_ser == tx_ser)));

endmodule

// File: rtl/loop_char_gate.sv
module loop_char_gate #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CHAR_W-1:0] out_data
);

  assign out_valid = en & in_valid;
  assign in_ready  = en ? out_ready : 1'b1;
  assign out_data  = in_data;

  // R7: a closed path swallows offers and shows nothing downstream
  assert_closed_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (in_ready && !out_valid));

  // R7: an open path keeps the handshake intact
  assert_open_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ((out_valid == in_valid) && (in_ready == out_ready)));

endmodule

// File: rtl/chan_loop_router.sv
module chan_loop_router
  import loop_router_pkg::*;
#(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic [1:0]        mode_cfg,
  input  logic              rxd_pin,
  output logic              txd_pin,
  input  logic              tx_ser_in,
  output logic              rx_ser_out,
  input  logic              cpu_tx_valid,
  output logic              cpu_tx_ready,
  input  logic [CHAR_W-1:0] cpu_tx_data,
  output logic              xmt_valid,
  input  logic              xmt_ready,
  output logic [CHAR_W-1:0] xmt_data,
  input  logic              rcv_valid,
  output logic              rcv_ready,
  input  logic [CHAR_W-1:0] rcv_data,
  output logic              cpu_rx_valid,
  input  logic              cpu_rx_ready,
  output logic [CHAR_W-1:0] cpu_rx_data,
  output logic              tx_path_en,
  output logic              rx_path_en
);

  loop_mode_e act_mode;

  loop_mode_reg u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .mode_cfg (mode_cfg),
    .act_mode (act_mode)
  );

  loop_serial_mux u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .act_mode (act_mode),
    .rxd      (rxd_pin),
    .tx_ser   (tx_ser_in),
    .txd      (txd_pin),
    .rx_ser   (rx_ser_out)
  );

  assign tx_path_en = tx_path_open(act_mode);
  assign rx_path_en = rx_path_open(act_mode);

  loop_char_gate #(.CHAR_W(CHAR_W)) u_tx_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (tx_path_en),
    .in_valid  (cpu_tx_valid),
    .in_ready  (cpu_tx_ready),
    .in_data   (cpu_tx_data),
    .out_valid (xmt_valid),
    .out_ready (xmt_ready),
    .out_data  (xmt_data)
  );

  loop_char_gate #(.CHAR_W(CHAR_W)) u_rx_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (rx_path_en),
    .in_valid  (rcv_valid),
    .in_ready  (rcv_ready),
    .in_data   (rcv_data),
    .out_valid (cpu_rx_valid),
    .out_ready (cpu_rx_ready),
    .out_data  (cpu_rx_data)
  );

  // R8: echo mode closes only the transmit side, remote closes both
  assert_path_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_path_en |-> rx_path_en));

  // R1: first cycle out of reset is normal with the line at mark
  assert_reset_state_R1: assert property (@(posedge clk)
    !$past(rst_n) |-> (act_mode == LM_NORMAL && tx_path_en && rx_path_en));

endmodule

// File: tb/chan_loop_router_tb.sv
module chan_loop_router_tb;

  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic bit_tick;
  logic [1:0] mode_cfg;
  logic rxd_pin, txd_pin, tx_ser_in, rx_ser_out;
  logic cpu_tx_valid, cpu_tx_ready, xmt_valid, xmt_ready;
  logic [CW-1:0] cpu_tx_data, xmt_data;
  logic rcv_valid, rcv_ready, cpu_rx_valid, cpu_rx_ready;
  logic [CW-1:0] rcv_data, cpu_rx_data;
  logic tx_path_en, rx_path_en;

  always #10 clk = ~clk;

  chan_loop_router #(.CHAR_W(CW)) u_dut (.*);

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [1:0] m_mode;
  logic m_echo;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (time %0t)", tag, what, act, exp, $time);
    end
  endtask

  function automatic string mtag(input logic [1:0] m);
    case (m)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Model update for the edge just passed (inputs were stable across it)
  task automatic step();
    @(negedge clk);
    if (!rst_n) begin
      m_mode = 2'b00; m_echo = 1'b1;
    end else if (bit_tick) begin
      m_mode = mode_cfg; m_echo = rxd_pin;
    end
  endtask

  task automatic check_all();
    logic e_txd, e_rx, t_open, r_open;
    string tg;
    #1;
    tg = mtag(m_mode);
    e_txd = (m_mode == 2'b00) ? tx_ser_in : (m_mode == 2'b10) ? 1'b1 : m_echo;
    e_rx  = (m_mode == 2'b10) ? tx_ser_in : rxd_pin;
    t_open = (m_mode == 2'b00) || (m_mode == 2'b10);
    r_open = (m_mode != 2'b11);
    chk(txd_pin, e_txd, tg, "txd_pin");
    chk(rx_ser_out, e_rx, tg, "rx_ser_out");
    chk(tx_path_en, t_open, "R8", "tx_path_en");
    chk(rx_path_en, r_open, "R8", "rx_path_en");
    chk(xmt_valid, t_open & cpu_tx_valid, "R7", "xmt_valid");
    chk(cpu_tx_ready, t_open ? xmt_ready : 1'b1, "R7", "cpu_tx_ready");
    if (t_open) chk(xmt_data, cpu_tx_data, "R7", "xmt_data");
    chk(cpu_rx_valid, r_open & rcv_valid, "R7", "cpu_rx_valid");
    chk(rcv_ready, r_open ? cpu_rx_ready : 1'b1, "R7", "rcv_ready");
    if (r_open) chk(cpu_rx_data, rcv_data, "R7", "cpu_rx_data");
  endtask

  task automatic rand_streams();
    cpu_tx_valid = $urandom % 2; xmt_ready = $urandom % 2; cpu_tx_data = CW'($urandom);
    rcv_valid = $urandom % 2; cpu_rx_ready = $urandom % 2; rcv_data = CW'($urandom);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; bit_tick = 1'b1; mode_cfg = 2'b11; rxd_pin = 1'b0; tx_ser_in = 1'b1;
    cpu_tx_valid = 0; xmt_ready = 0; cpu_tx_data = '0;
    rcv_valid = 0; cpu_rx_ready = 0; rcv_data = '0;
    repeat (3) step();
    rst_n = 1'b1; bit_tick = 1'b0;
    check_all();
    // R1: reset state
    chk(txd_pin, 1'b1, "R1", "txd idle at mark");
    chk(tx_path_en & rx_path_en, 1'b1, "R1", "paths open");

    // R2 directed: select local on a tick, then request remote without tick
    step(); mode_cfg = 2'b10; bit_tick = 1'b1; check_all();
    step(); bit_tick = 1'b0; mode_cfg = 2'b11; rxd_pin = 1'b0; tx_ser_in = 1'b0; check_all();
    for (int i = 0; i < 4; i++) begin
      step(); rxd_pin = ~rxd_pin; check_all();
      chk(txd_pin, 1'b1, "R2", "mode held without tick");
      chk(rx_ser_out, tx_ser_in, "R5", "rxd ignored in local");
    end

    // R9 directed: echo mode, tick loads 0, rxd moves without tick
    step(); mode_cfg = 2'b01; bit_tick = 1'b1; rxd_pin = 1'b0; check_all();
    step(); bit_tick = 1'b0; rxd_pin = 1'b1; check_all();
    chk(txd_pin, 1'b0, "R9", "echo loaded at tick");
    step(); rxd_pin = 1'b0; check_all();
    step(); rxd_pin = 1'b1; check_all();
    chk(txd_pin, 1'b0, "R9", "echo held between ticks");
    step(); bit_tick = 1'b1; check_all();
    step(); bit_tick = 1'b0; check_all();
    chk(txd_pin, 1'b1, "R4", "echo follows tick sample");

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      step();
      bit_tick = ($urandom % 4) == 0;
      if (($urandom % 8) == 0) mode_cfg = 2'($urandom);
      rxd_pin = $urandom % 2;
      tx_ser_in = $urandom % 2;
      rand_streams();
      if (n == 2000) rst_n = 1'b0;
      if (n == 2003) rst_n = 1'b1;
      check_all();
    end

    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule